// File: doc/BRIEF.md
# Aligned Two-Rate Reset Release

This block turns one asynchronous, active-low reset request into two reset outputs: one for registers on a slow clock and one for registers on a fast clock running at exactly twice the slow frequency, phase-locked to it. Reset takes effect at once in both domains. Release passes through a single shared synchronizer. It is timed so that the slow-domain and fast-domain registers leave reset on the same clock instant. That instant is a slow-clock falling edge, which coincides with a fast-clock rising edge. The registers then take their first step together on the next edge, which both clocks share.

Two build-time variants are offered. In the default variant the synchronizer stages are clocked on the falling edge of the slow clock, so each release step already lands on a shared edge. In the alternative variant the stages run on the fast clock. A final gate stage then lets the release through only on a fast rising edge that coincides with a slow falling edge. The gate delays a release that would otherwise land on a slow rising edge by one fast cycle. Each domain has a small free-running demonstration counter that is held at zero in reset, so the alignment can be seen at the ports.

Top module: `mrr_reset_align`

## Requirements
- R1: While `arst_n` is low, `slow_rst` and `fast_rst` are 1 and both counters are 0. This takes effect in the same time step that `arst_n` falls, with no clock edge needed.
- R2: All release paths go through one synchronizer, and `slow_rst` and `fast_rst` go from 1 to 0 at the same instant.
- R3: Release happens only at a slow-clock falling edge. The first increment of the slow counter (0 to 1) and of the fast counter (0 to 1) happen on the same following edge.
- R4: With MODE = SYNC_SLOW_FALL, when `arst_n` rises away from any clock edge, both resets drop at the STAGES-th slow falling edge after the rise.
- R5: With MODE = SYNC_FAST_GATED, both resets drop at the first fast rising edge that is at least the (STAGES+1)-th after the rise of `arst_n` and that coincides with a slow falling edge. If that (STAGES+1)-th edge coincides with a slow rising edge, release waits exactly one more fast cycle.
- R6: After release, the slow counter adds 1 on every slow rising edge and the fast counter adds 1 on every fast rising edge. Both counters are CNT_W bits wide and wrap.
- R7: Once released, both resets stay at 0 for as long as `arst_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Slow clock, half the fast frequency, rising edges aligned with fast rising edges |
| clk_fast | input | 1 | Fast clock |
| arst_n | input | 1 | Asynchronous reset request, active low |
| slow_rst | output | 1 | Active-high reset for slow-domain registers |
| fast_rst | output | 1 | Active-high reset for fast-domain registers |
| slow_cnt | output | CNT_W | Slow-domain demonstration counter |
| fast_cnt | output | CNT_W | Fast-domain demonstration counter |

## Verification
The bench builds two copies side by side and drives both from one reset request. The first copy uses the slow-falling-edge synchronizer with two stages. The second uses the fast-clock gated synchronizer with three stages. Because the second copy's first candidate edge is the fourth fast edge, releasing the request in either slow-clock phase produces both outcomes of the fast variant: immediate release, and release held back by one cycle. The same pulses also exercise the default variant's two-falling-edge latency in both phases.

// File: rtl/mrr_pkg.sv
package mrr_pkg;
  typedef enum logic {
    SYNC_SLOW_FALL  = 1'b0,
    SYNC_FAST_GATED = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/mrr_sync_chain.sv
// Shift chain that reloads zeros while arst_n is low and shifts ones in after.
module mrr_sync_chain #(
  parameter int STAGES  = 2,
  parameter bit ON_FALL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  output logic rel_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  assign stage_d = STAGES'({stage_q, 1'b1});

  generate
    if (ON_FALL) begin : g_fall
      always_ff @(negedge clk or negedge arst_n) begin
        if (!arst_n) stage_q <= '0;
        else         stage_q <= stage_d;
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q <= '0;
        else         stage_q <= stage_d;
      end
    end
  endgenerate

  assign rel_o = stage_q[STAGES-1];
endmodule

// File: rtl/mrr_phase_detect.sv
// Flags, in the fast domain, the fast rising edges that coincide with a
// slow falling edge. Valid from the second fast edge after arst_n rises.
module mrr_phase_detect (
  input  logic clk_slow,
  input  logic clk_fast,
  input  logic arst_n,
  output logic slow_fall_o
);
  logic tgl_q;
  logic seen_q;

  always_ff @(posedge clk_slow or negedge arst_n) begin
    if (!arst_n) tgl_q <= 1'b0;
    else         tgl_q <= ~tgl_q;
  end

  always_ff @(posedge clk_fast or negedge arst_n) begin
    if (!arst_n) seen_q <= 1'b0;
    else         seen_q <= tgl_q;
  end

  assign slow_fall_o = tgl_q ^ seen_q;
endmodule

// File: rtl/mrr_demo_counter.sv
module mrr_demo_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mrr_reset_align.sv
module mrr_reset_align #(
  parameter mrr_pkg::sync_mode_e MODE = mrr_pkg::SYNC_SLOW_FALL,
  parameter int STAGES = 2,
  parameter int CNT_W  = 8
) (
  input  logic             clk_slow,
  input  logic             clk_fast,
  input  logic             arst_n,
  output logic             slow_rst,
  output logic             fast_rst,
  output logic [CNT_W-1:0] slow_cnt,
  output logic [CNT_W-1:0] fast_cnt
);
  logic rel;

  generate
    if (MODE == mrr_pkg::SYNC_SLOW_FALL) begin : g_slow
      mrr_sync_chain #(.STAGES(STAGES), .ON_FALL(1'b1)) u_chain (
        .clk    (clk_slow),
        .arst_n (arst_n),
        .rel_o  (rel)
      );
    end else begin : g_fast
      logic chain_rel;
      logic slow_fall;
      logic gate_q;

      mrr_sync_chain #(.STAGES(STAGES), .ON_FALL(1'b0)) u_chain (
        .clk    (clk_fast),
        .arst_n (arst_n),
        .rel_o  (chain_rel)
      );

      mrr_phase_detect u_phase (
        .clk_slow    (clk_slow),
        .clk_fast    (clk_fast),
        .arst_n      (arst_n),
        .slow_fall_o (slow_fall)
      );

      // Let the release through only on a fast edge shared with a slow fall.
      always_ff @(posedge clk_fast or negedge arst_n) begin
        if (!arst_n)                     gate_q <= 1'b0;
        else if (chain_rel && slow_fall) gate_q <= 1'b1;
      end

      assign rel = gate_q;
    end
  endgenerate

  assign slow_rst = ~rel;
  assign fast_rst = ~rel;

  mrr_demo_counter #(.W(CNT_W)) u_slow_cnt (
    .clk   (clk_slow),
    .rst   (slow_rst),
    .cnt_o (slow_cnt)
  );

  mrr_demo_counter #(.W(CNT_W)) u_fast_cnt (
    .clk   (clk_fast),
    .rst   (fast_rst),
    .cnt_o (fast_cnt)
  );
endmodule

// File: rtl/mrr_reset_align_chk.sv
module mrr_reset_align_chk #(
  parameter mrr_pkg::sync_mode_e MODE = mrr_pkg::SYNC_SLOW_FALL,
  parameter int STAGES = 2,
  parameter int CNT_W  = 8
) (
  input logic             clk_slow,
  input logic             clk_fast,
  input logic             arst_n,
  input logic             slow_rst,
  input logic             fast_rst,
  input logic [CNT_W-1:0] slow_cnt,
  input logic [CNT_W-1:0] fast_cnt
);
  localparam int MIN_EDGES = (MODE == mrr_pkg::SYNC_FAST_GATED) ? STAGES + 1 : 2 * STAGES - 1;

  logic [7:0] hi_cnt;
  always_ff @(posedge clk_fast or negedge arst_n) begin
    if (!arst_n)            hi_cnt <= '0;
    else if (hi_cnt != '1)  hi_cnt <= hi_cnt + 1'b1;
  end

  // R1: reset request forces both resets and clears both counters
  assert_reset_hold_R1: assert property (@(negedge clk_fast)
    !arst_n |-> (fast_rst && slow_rst && fast_cnt == '0 && slow_cnt == '0));

  // R3: release is seen just before a slow rising edge, so it was on a slow fall
  assert_release_on_fall_R3: assert property (@(posedge clk_fast) disable iff (!arst_n)
    $fell(slow_rst) |-> !clk_slow);

  // R3: both counters take their first step on the same edge
  assert_first_step_together_R3: assert property (@(posedge clk_fast) disable iff (!arst_n)
    ($past(fast_rst, 2) && !$past(fast_rst)) |-> (fast_cnt == 1 && slow_cnt == 1));

  // R4, R5: release never comes earlier than the synchronizer allows
  assert_min_latency_R4: assert property (@(posedge clk_fast) disable iff (!arst_n)
    $fell(fast_rst) |-> (int'(hi_cnt) >= MIN_EDGES));

  // R7: released resets stay released while the request is high
  assert_stay_released_R7: assert property (@(posedge clk_fast) disable iff (!arst_n)
    (!fast_rst && !slow_rst) |=> (!fast_rst && !slow_rst));
endmodule

bind mrr_reset_align mrr_reset_align_chk #(
  .MODE   (MODE),
  .STAGES (STAGES),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_slow (clk_slow),
  .clk_fast (clk_fast),
  .arst_n   (arst_n),
  .slow_rst (slow_rst),
  .fast_rst (fast_rst),
  .slow_cnt (slow_cnt),
  .fast_cnt (fast_cnt)
);

// File: tb/sim_mrr_reset_align.sv
module sim_mrr_reset_align;
  localparam int STG0  = 2;
  localparam int STG1  = 3;
  localparam int CNT_W = 8;

  logic clk_fast = 1'b0;
  logic clk_slow = 1'b0;
  logic arst_n   = 1'b0;

  logic             r0_slow, r0_fast, r1_slow, r1_fast;
  logic [CNT_W-1:0] c0_slow, c0_fast, c1_slow, c1_fast;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  mrr_reset_align #(.MODE(mrr_pkg::SYNC_SLOW_FALL), .STAGES(STG0), .CNT_W(CNT_W)) u0 (
    .clk_slow (clk_slow), .clk_fast (clk_fast), .arst_n (arst_n),
    .slow_rst (r0_slow), .fast_rst (r0_fast), .slow_cnt (c0_slow), .fast_cnt (c0_fast)
  );

  mrr_reset_align #(.MODE(mrr_pkg::SYNC_FAST_GATED), .STAGES(STG1), .CNT_W(CNT_W)) u1 (
    .clk_slow (clk_slow), .clk_fast (clk_fast), .arst_n (arst_n),
    .slow_rst (r1_slow), .fast_rst (r1_fast), .slow_cnt (c1_slow), .fast_cnt (c1_fast)
  );

  // 100 MHz fast clock; slow clock toggles on every fast rising edge
  initial begin
    forever begin
      #5 clk_fast = 1'b1; clk_slow = ~clk_slow;
      #5 clk_fast = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_held(input string when);
    chk(r0_slow == 1'b1 && r0_fast == 1'b1, {"R1 u0 resets ", when}, int'({r0_slow, r0_fast}), 3);
    chk(r1_slow == 1'b1 && r1_fast == 1'b1, {"R1 u1 resets ", when}, int'({r1_slow, r1_fast}), 3);
    chk(c0_slow == 0 && c0_fast == 0, {"R1 u0 counters ", when}, int'(c0_slow) + int'(c0_fast), 0);
    chk(c1_slow == 0 && c1_fast == 0, {"R1 u1 counters ", when}, int'(c1_slow) + int'(c1_fast), 0);
  endtask

  // One reset pulse: release in the requested slow phase, follow both copies
  // edge by edge, then drop the request mid-cycle and check the async reset.
  task automatic run_pulse(input bit first_fall, input int edges, input int low_ns);
    int falls = 0;
    int e0 = 0;
    int e1 = 0;
    int s0 = 0;
    int s1 = 0;
    @(negedge clk_fast);
    while (clk_slow !== first_fall) @(negedge clk_fast);
    #2 arst_n = 1'b1;
    for (int n = 1; n <= edges; n++) begin
      bit fe;
      @(posedge clk_fast);
      #1;
      fe = !clk_slow;
      if (fe) falls++;
      if (e0 == 0 && falls == STG0) e0 = n;
      if (e0 != 0 && n > e0 && !fe) s0++;
      if (e1 == 0 && n >= STG1 + 1 && fe) e1 = n;
      if (e1 != 0 && n > e1 && !fe) s1++;

      // R4, R2: default copy, both resets drop together at the STG0-th fall
      chk(r0_fast == (e0 == 0) && r0_slow == (e0 == 0), "R4,R2 u0 release edge",
          int'({r0_slow, r0_fast}), (e0 == 0) ? 3 : 0);
      // R5, R2: gated copy releases only on a shared edge
      chk(r1_fast == (e1 == 0) && r1_slow == (e1 == 0), "R5,R2 u1 release edge",
          int'({r1_slow, r1_fast}), (e1 == 0) ? 3 : 0);
      if (n == STG1 + 1 && !fe)
        chk(r1_fast == 1'b1, "R5 u1 held one fast cycle", int'(r1_fast), 1);
      // R6: counters follow their own clocks after release
      chk(int'(c0_fast) == ((e0 == 0) ? 0 : n - e0), "R6 u0 fast count", int'(c0_fast),
          (e0 == 0) ? 0 : n - e0);
      chk(int'(c0_slow) == s0, "R6 u0 slow count", int'(c0_slow), s0);
      chk(int'(c1_fast) == ((e1 == 0) ? 0 : n - e1), "R6 u1 fast count", int'(c1_fast),
          (e1 == 0) ? 0 : n - e1);
      chk(int'(c1_slow) == s1, "R6 u1 slow count", int'(c1_slow), s1);
      // R3: first step taken together
      if (e0 != 0 && n == e0 + 1)
        chk(c0_fast == 1 && c0_slow == 1, "R3 u0 first step", int'(c0_slow), 1);
      if (e1 != 0 && n == e1 + 1)
        chk(c1_fast == 1 && c1_slow == 1, "R3 u1 first step", int'(c1_slow), 1);
    end
    // R7: still released at the end of the window
    chk(r0_fast == 1'b0 && r1_fast == 1'b0, "R7 resets stay released",
        int'({r0_fast, r1_fast}), 0);
    #2 arst_n = 1'b0;
    #1 check_held("after mid-cycle drop");
    #(low_ns);
  endtask

  initial begin
    #23 check_held("at start");
    run_pulse(1'b1, 24, 7);
    run_pulse(1'b0, 24, 31);
    run_pulse(1'b0, 20, 3);
    run_pulse(1'b1, 20, 55);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule